// File: doc/BRIEF.md
# Phase-Frequency Detector with Polarity Select

This block compares a reference pulse stream against a divided oscillator pulse stream and issues pump-up and pump-down requests toward a charge pump. Both inputs are sampled on a fast system clock through a synchronizer. A rising edge on either input sets that input's request flop. Once both flops are set, a clear interval holds both requests high for a programmable number of clock cycles and then clears them together. Because of this interval, a zero phase error still produces a short pulse on both outputs, which removes the dead zone around lock.

A polarity input swaps the two requests, so the same loop can drive an inverting or a non-inverting loop filter. A high-impedance flag is raised whenever neither request is active, which tells the pump stage to float its output. A current-level select bit is registered and passed on to choose between the high and low pump current.

Top module: `phase_freq_detector`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns `pump_up`=0, `pump_dn`=0, `pump_hiz`=1 and `cur_hi`=0 after that edge.
- R2: An input level is seen as a rising edge SYNC_STAGES+1 clock edges after it is first sampled high. A rising edge on `ref_in` sets the reference request unless a clear interval is in progress. Once set, the request stays set until the clear interval ends.
- R3: A rising edge on `fb_in` sets the feedback request in the same way. The same timing and clear-interval rules as in R2 apply.
- R4: When both requests are set, both stay high for exactly MIN_OVERLAP cycles and then clear together. At zero phase offset, each output therefore pulses for MIN_OVERLAP cycles.
- R5: When one input leads the other by d sampled cycles, the leading request is high for d+MIN_OVERLAP cycles and the lagging request for MIN_OVERLAP cycles.
- R6: With `polarity_inv`=0, `pump_up` carries the reference request and `pump_dn` the feedback request. With `polarity_inv`=1, the two are exchanged.
- R7: `pump_hiz` is 1 exactly when both `pump_up` and `pump_dn` are 0.
- R8: `cur_hi` equals the `cur_sel` value sampled at the previous clock edge (1 = high pump current, 0 = low).
- R9: A rising edge that arrives during the clear interval is dropped and does not set its request after the interval ends.
- R10: Further rising edges of an input whose request is already set have no effect. The request still clears only after the other input's edge plus the clear interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Reference pulse stream |
| fb_in | input | 1 | Divided oscillator pulse stream |
| polarity_inv | input | 1 | 1 swaps the up and down requests |
| cur_sel | input | 1 | Pump current select (1 high, 0 low) |
| pump_up | output | 1 | Source-current request |
| pump_dn | output | 1 | Sink-current request |
| pump_hiz | output | 1 | High when no request is active |
| cur_hi | output | 1 | Registered current select |

## Verification
Edge pairs are applied with the reference leading, with the feedback leading, and with both edges coincident, under each polarity setting. The coincident case isolates the forced overlap width. The leading cases show that the pulse width grows by the offset on the correct output, and repeating them with the polarity flipped shows that the swap moves the whole pulse rather than only its label. Two further patterns cover the remaining rules: a second reference edge placed inside the clear interval checks that dropped edges stay dropped, and several reference edges before one feedback edge show frequency-detector behaviour. A behavioural model is compared against every output on every clock.

// File: rtl/pfd_pkg.sv
// Package: shared types for the phase-frequency detector.
// Assumes: channel index 0 is the reference, index 1 the feedback.
package pfd_pkg;
    localparam int CH_REF = 0;
    localparam int CH_FB  = 1;
    localparam int N_CH   = 2;

    typedef struct packed {
        logic up;   // reference request
        logic dn;   // feedback request
    } pump_req_t;
endpackage

// File: rtl/pfd_edge_sync.sv
// Module: synchronizes one asynchronous input and flags its rising edge.
// Assumes: SYNC_STAGES >= 1. The flag is one cycle wide and appears
// SYNC_STAGES+1 edges after the first high sample.
module pfd_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [SYNC_STAGES:0] chain;

    // Shift the sampled input through the synchronizer and the history bit.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[SYNC_STAGES-1:0], din};
    end

    // Rising edge: the newest synchronized bit is high and the older one is low.
    always_comb rise = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];
endmodule

// File: rtl/pfd_core.sv
// Module: the two request flops of the detector and their shared clear interval.
// Assumes: MIN_OVERLAP >= 1. Edges arriving during the clear interval are dropped.
module pfd_core
    import pfd_pkg::*;
#(
    parameter int MIN_OVERLAP = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ref_rise,
    input  logic      fb_rise,
    output pump_req_t req
);
    localparam int CNT_W = $clog2(MIN_OVERLAP + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_OVERLAP - 1);

    logic             up_q, dn_q;
    logic [CNT_W-1:0] hold_cnt;
    logic             both_set;

    always_comb both_set = up_q & dn_q;

    // Set the request flops on edges, or run the clear interval once both are set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_q     <= 1'b0;
            dn_q     <= 1'b0;
            hold_cnt <= '0;
        end else if (both_set) begin
            if (hold_cnt == LAST) begin
                up_q     <= 1'b0;
                dn_q     <= 1'b0;
                hold_cnt <= '0;
            end else begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end else begin
            up_q     <= up_q | ref_rise;
            dn_q     <= dn_q | fb_rise;
            hold_cnt <= '0;
        end
    end

    // Present the flop states as a request pair.
    always_comb begin
        req.up = up_q;
        req.dn = dn_q;
    end

    // R2
    ref_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_rise && !both_set) |=> up_q);
    // R3
    fb_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_rise && !both_set) |=> dn_q);
    // R4
    overlap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (both_set && hold_cnt != LAST) |=> (up_q && dn_q));
    // R4
    overlap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (both_set && hold_cnt == LAST) |=> (!up_q && !dn_q));
    // R10
    single_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_q && !dn_q) |=> up_q);
endmodule

// File: rtl/pfd_out_stage.sv
// Module: applies the polarity swap, raises the float flag, registers the current select.
// Assumes: polarity_inv is quasi-static; the swap is combinational.
module pfd_out_stage
    import pfd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pump_req_t req,
    input  logic      polarity_inv,
    input  logic      cur_sel,
    output logic      pump_up,
    output logic      pump_dn,
    output logic      pump_hiz,
    output logic      cur_hi
);
    // Route the requests according to the polarity and flag the idle state.
    always_comb begin
        pump_up  = polarity_inv ? req.dn : req.up;
        pump_dn  = polarity_inv ? req.up : req.dn;
        pump_hiz = ~(req.up | req.dn);
    end

    // Register the current-level select.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_hi <= 1'b0;
        else        cur_hi <= cur_sel;
    end

    // R8
    cur_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cur_hi == $past(cur_sel)));
endmodule

// File: rtl/phase_freq_detector.sv
// Module: top of the phase-frequency detector with polarity select.
// Assumes: ref_in and fb_in are asynchronous pulse streams slower than clk.
module phase_freq_detector
    import pfd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_OVERLAP = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic fb_in,
    input  logic polarity_inv,
    input  logic cur_sel,
    output logic pump_up,
    output logic pump_dn,
    output logic pump_hiz,
    output logic cur_hi
);
    logic [N_CH-1:0] raw_in;
    logic [N_CH-1:0] rise_v;
    pump_req_t       req;

    // Gather both inputs so one synchronizer is generated per channel.
    always_comb begin
        raw_in[CH_REF] = ref_in;
        raw_in[CH_FB]  = fb_in;
    end

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_sync
        pfd_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_in[ch]),
            .rise (rise_v[ch])
        );
    end

    pfd_core #(.MIN_OVERLAP(MIN_OVERLAP)) i_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_rise(rise_v[CH_REF]),
        .fb_rise (rise_v[CH_FB]),
        .req     (req)
    );

    pfd_out_stage i_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .polarity_inv(polarity_inv),
        .cur_sel     (cur_sel),
        .pump_up     (pump_up),
        .pump_dn     (pump_dn),
        .pump_hiz    (pump_hiz),
        .cur_hi      (cur_hi)
    );
endmodule

// File: tb/test_phase_freq_detector.sv
module test_phase_freq_detector;
    localparam int CLK_P = 10;
    localparam int SYNC  = 2;
    localparam int MINO  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0, fb_in = 1'b0, polarity_inv = 1'b0, cur_sel = 1'b0;
    logic pump_up, pump_dn, pump_hiz, cur_hi;

    int n_chk = 0, n_fail = 0;
    int up_seen = 0, dn_seen = 0;
    bit done = 0;

    // behavioural reference state
    bit rq[$], fq[$];
    bit m_up = 0, m_dn = 0, m_cur = 0, r_rise, f_rise;
    int m_hold = 0;

    always #(CLK_P/2) clk = ~clk;

    phase_freq_detector #(.SYNC_STAGES(SYNC), .MIN_OVERLAP(MINO)) i_phase_freq_detector (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .polarity_inv(polarity_inv), .cur_sel(cur_sel),
        .pump_up(pump_up), .pump_dn(pump_dn), .pump_hiz(pump_hiz), .cur_hi(cur_hi)
    );

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_int(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Model update at each edge, then compare a quarter period later.
    always @(posedge clk) begin
        if (!rst_n) begin
            rq = {}; fq = {};
            for (int i = 0; i <= SYNC; i++) begin rq.push_back(0); fq.push_back(0); end
            m_up = 0; m_dn = 0; m_hold = 0; m_cur = 0;
        end else begin
            r_rise = rq[SYNC-1] && !rq[SYNC];
            f_rise = fq[SYNC-1] && !fq[SYNC];
            if (m_up && m_dn) begin
                if (m_hold == MINO - 1) begin m_up = 0; m_dn = 0; m_hold = 0; end
                else m_hold++;
            end else begin
                m_up = m_up | r_rise;
                m_dn = m_dn | f_rise;
            end
            rq.push_front(ref_in); void'(rq.pop_back());
            fq.push_front(fb_in);  void'(fq.pop_back());
            m_cur = cur_sel;
        end
        #(CLK_P/4);
        if (rq.size() > 0) begin
            chk("R6 pump_up", pump_up, polarity_inv ? m_dn : m_up);
            chk("R6 pump_dn", pump_dn, polarity_inv ? m_up : m_dn);
            chk("R7 pump_hiz", pump_hiz, !(m_up || m_dn));
            chk("R8 cur_hi", cur_hi, m_cur);
        end
        if (pump_up === 1'b1) up_seen++;
        if (pump_dn === 1'b1) dn_seen++;
    end

    // One edge pair: the leader rises d cycles before the other input.
    task automatic pair(int d, bit ref_lead, bit pol, string tag);
        int lead_w, lag_w, exp_r, exp_f;
        @(negedge clk);
        polarity_inv = pol; up_seen = 0; dn_seen = 0;
        if (d > 0) begin
            if (ref_lead) ref_in = 1'b1; else fb_in = 1'b1;
            repeat (d) @(negedge clk);
        end
        ref_in = 1'b1; fb_in = 1'b1;
        repeat (4) @(negedge clk);
        ref_in = 1'b0; fb_in = 1'b0;
        repeat (MINO + d + 10) @(negedge clk);
        lead_w = d + MINO; lag_w = MINO;
        exp_r = ref_lead ? lead_w : lag_w;
        exp_f = ref_lead ? lag_w : lead_w;
        chk_int({tag, " up width"}, up_seen, pol ? exp_f : exp_r);
        chk_int({tag, " dn width"}, dn_seen, pol ? exp_r : exp_f);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 pump_up", pump_up, 1'b0);
        chk("R1 pump_dn", pump_dn, 1'b0);
        chk("R1 pump_hiz", pump_hiz, 1'b1);
        chk("R1 cur_hi", cur_hi, 1'b0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        pair(0, 1'b1, 1'b0, "R4 zero offset");
        pair(0, 1'b1, 1'b1, "R4 zero offset inv");
        pair(5, 1'b1, 1'b0, "R2 R5 ref leads");
        pair(5, 1'b1, 1'b1, "R6 R5 ref leads inv");
        pair(7, 1'b0, 1'b0, "R3 R5 fb leads");
        pair(7, 1'b0, 1'b1, "R6 R5 fb leads inv");

        // R9: second ref edge lands inside the clear interval
        @(negedge clk); polarity_inv = 1'b0; up_seen = 0; dn_seen = 0;
        ref_in = 1'b1; fb_in = 1'b1;
        @(negedge clk); ref_in = 1'b0;
        @(negedge clk); ref_in = 1'b1;
        @(negedge clk); ref_in = 1'b0; fb_in = 1'b0;
        repeat (15) @(negedge clk);
        chk_int("R9 up width", up_seen, MINO);
        chk_int("R9 dn width", dn_seen, MINO);
        chk("R9 idle after", pump_hiz, 1'b1);

        // R10: two ref edges before one fb edge
        @(negedge clk); up_seen = 0; dn_seen = 0;
        ref_in = 1'b1; repeat (2) @(negedge clk);
        ref_in = 1'b0; repeat (2) @(negedge clk);
        ref_in = 1'b1; repeat (4) @(negedge clk);
        fb_in = 1'b1; repeat (3) @(negedge clk);
        ref_in = 1'b0; fb_in = 1'b0;
        repeat (15) @(negedge clk);
        chk_int("R10 up width", up_seen, 8 + MINO);
        chk_int("R10 dn width", dn_seen, MINO);

        // R8: current select follows one edge later
        @(negedge clk); cur_sel = 1'b1;
        @(negedge clk); chk("R8 cur_hi high", cur_hi, 1'b1);
        cur_sel = 1'b0;
        @(negedge clk); chk("R8 cur_hi low", cur_hi, 1'b0);

        // R1 again: reset in the middle of a request
        ref_in = 1'b1; repeat (5) @(negedge clk);
        rst_n = 1'b0; @(negedge clk);
        chk("R1 mid reset up", pump_up, 1'b0);
        chk("R1 mid reset hiz", pump_hiz, 1'b1);
        ref_in = 1'b0; rst_n = 1'b1;
        repeat (4) @(negedge clk);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule